// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 12-bit successive-approximation converter. It runs from a clock at twice the conversion clock rate and produces the conversion clock itself, so every half period of the conversion clock is one edge of the fast clock and all state changes stay synchronous. An active-low start strobe arms a conversion. The conversion begins on the next rising edge of the conversion clock. A sampling phase comes first. The bits are then resolved one at a time from the MSB down to the LSB, using a trial code that drives the capacitor DAC and a one-bit comparator result that comes back to the block.

The bit decisions do not all last the same time. Bit 5 gets two conversion-clock periods and bit 0 gets one and a half. Every other bit gets one period, so the decisions take 13.5 periods in total. The busy output is low from the start of sampling until the LSB has been decided. The final code leaves the block on a valid/ready result port.

Back-pressure works as follows. The code is held stable with valid high until ready is seen high at a clock edge. While an unaccepted result is pending, any start strobe is dropped. A consumer that holds ready high therefore sees valid for exactly one cycle, and conversions can follow one another at full rate.

Top module: `sar_seq`

## Requirements
- R1: During and after reset, busy_n is 1, conv_clk is 0, sample_en is 0, res_valid is 0 and dac_code is 0.
- R2: conv_clk toggles on every clk2x edge. When start_n is seen low (or was seen low earlier while idle), busy_n falls on the first clk2x edge at which conv_clk rises (conv_clk was 0 before that edge), and conv_clk reads 1 immediately afterwards.
- R3: sample_en is 1 for exactly 5 clk2x periods (2.5 conversion periods), starting at the edge where busy_n falls. dac_code stays 0 throughout.
- R4: Bits are resolved from bit 11 down to bit 0. At the start of each bit's window, that bit is set to 1 in dac_code. At the last edge of the window it is cleared if cmp_hi is 1 (1 = DAC output above the input). With cmp_hi = (dac_code > vin), res_code equals vin.
- R5: The decision window of every bit other than 5 and 0 lasts 2 clk2x periods. Bit 11 is set 5 periods after busy_n falls and bit 10 is set 7 periods after it falls.
- R6: The window of bit 5 lasts 4 clk2x periods. Bit 5 is set 17 periods after busy_n falls and bit 4 is set 21 periods after it falls.
- R7: The window of bit 0 lasts 3 clk2x periods. Bit 0 is set 29 periods after busy_n falls, so the decisions take 27 clk2x periods in total.
- R8: busy_n stays low for exactly 32 clk2x periods. It rises on the same edge that sets res_valid and loads res_code.
- R9: While res_valid is 1 and res_ready is 0, res_valid stays 1 and res_code does not change. res_valid clears on the edge where res_ready is 1.
- R10: A start strobe while busy_n is low is ignored. The running conversion still lasts 32 periods and no second conversion follows.
- R11: A start strobe while res_valid is 1 is ignored. busy_n stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the conversion clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| start_n | input | 1 | Active-low conversion start strobe |
| cmp_hi | input | 1 | Comparator result, 1 when the DAC output is above the sampled input |
| conv_clk | output | 1 | Generated conversion clock (clk2x divided by two) |
| sample_en | output | 1 | High during the sampling phase |
| busy_n | output | 1 | Low for the whole conversion |
| dac_code | output | 12 | Trial code driving the capacitor DAC |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted by the consumer |
| res_code | output | 12 | Converted code |

## Verification
All results are timed from the clk2x edge where busy_n falls. That edge comes one edge after the strobe when conv_clk reads 0, and two edges after it when conv_clk reads 1. Sampling ends 5 edges later. The bits are set at offsets 5, 7, ..., 15, 17, 21, 23, 25, 27 and 29, and busy_n and res_valid change at offset 32. The bench samples on the falling edge of clk2x, counts falling edges from the first one where busy_n reads 0, and compares each recorded offset with these computed values. The comparator is modelled as a comparison of dac_code with a target value, so the expected code is simply that value.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_DECIDE = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_phase.sv
// Divides clk2x by two; rise_next marks the edge where conv_clk goes high.
module sar_phase (
  input  logic clk2x,
  input  logic rst_n,
  output logic conv_clk,
  output logic rise_next
);
  logic phase_q;

  always_ff @(posedge clk2x) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign conv_clk  = phase_q;
  assign rise_next = ~phase_q;
endmodule

// File: rtl/sar_ctrl.sv
// Phase sequencer: idle -> sample -> per-bit decision windows of uneven length.
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int NBITS        = 12,
  parameter int SAMPLE_HALF  = 5,
  parameter int BASE_HALF    = 2,
  parameter int STRETCH_BIT  = 5,
  parameter int STRETCH_HALF = 4,
  parameter int LSB_HALF     = 3,
  localparam int BW   = $clog2(NBITS),
  localparam int MAXA = (SAMPLE_HALF > STRETCH_HALF) ? SAMPLE_HALF : STRETCH_HALF,
  localparam int MAXB = (LSB_HALF > BASE_HALF) ? LSB_HALF : BASE_HALF,
  localparam int MAXW = (MAXA > MAXB) ? MAXA : MAXB,
  localparam int CW   = $clog2(MAXW + 1)
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          start_n,
  input  logic          rise_next,
  input  logic          res_valid,
  output logic          begin_o,
  output logic          first_o,
  output logic          step_o,
  output logic          last_o,
  output logic [BW-1:0] bit_o,
  output logic          busy_n,
  output logic          sample_en
);
  sar_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic          pend_q;
  logic [CW-1:0] win_last;
  logic [CW-1:0] samp_last;

  assign samp_last = CW'(SAMPLE_HALF - 1);

  always_comb begin
    if (bit_q == '0)                    win_last = CW'(LSB_HALF - 1);
    else if (bit_q == BW'(STRETCH_BIT)) win_last = CW'(STRETCH_HALF - 1);
    else                                win_last = CW'(BASE_HALF - 1);
  end

  assign begin_o = (state_q == ST_IDLE) && !res_valid && rise_next
                   && (!start_n || pend_q);
  assign first_o = (state_q == ST_SAMPLE) && (cnt_q == samp_last);
  assign step_o  = (state_q == ST_DECIDE) && (cnt_q == win_last);
  assign last_o  = step_o && (bit_q == '0);
  assign bit_o   = bit_q;
  assign busy_n    = (state_q == ST_IDLE);
  assign sample_en = (state_q == ST_SAMPLE);

  always_ff @(posedge clk2x) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (res_valid) begin
            pend_q <= 1'b0;
          end else if (begin_o) begin
            state_q <= ST_SAMPLE;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
          end else if (!start_n) begin
            pend_q <= 1'b1;
          end
        end
        ST_SAMPLE: begin
          pend_q <= 1'b0;
          if (first_o) begin
            state_q <= ST_DECIDE;
            cnt_q   <= '0;
            bit_q   <= BW'(NBITS - 1);
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_DECIDE: begin
          pend_q <= 1'b0;
          if (step_o) begin
            cnt_q <= '0;
            if (bit_q == '0) state_q <= ST_IDLE;
            else             bit_q   <= bit_q - BW'(1);
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_trial.sv
// Trial register and result holding stage.
module sar_trial #(
  parameter int NBITS = 12,
  localparam int BW = $clog2(NBITS)
) (
  input  logic             clk2x,
  input  logic             rst_n,
  input  logic             begin_i,
  input  logic             first_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic [BW-1:0]    bit_i,
  input  logic             cmp_hi,
  input  logic             res_ready,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-1:0] res_code,
  output logic             res_valid
);
  logic [NBITS-1:0] trial_q;
  logic [NBITS-1:0] nxt;

  always_comb begin
    nxt = trial_q;
    if (cmp_hi)       nxt[bit_i] = 1'b0;
    if (bit_i != '0)  nxt[bit_i - BW'(1)] = 1'b1;
  end

  always_ff @(posedge clk2x) begin
    if (!rst_n) begin
      trial_q   <= '0;
      res_code  <= '0;
      res_valid <= 1'b0;
    end else begin
      if (begin_i)      trial_q <= '0;
      else if (first_i) trial_q <= {1'b1, {(NBITS-1){1'b0}}};
      else if (step_i)  trial_q <= nxt;

      if (last_i) begin
        res_code  <= nxt;
        res_valid <= 1'b1;
      end else if (res_valid && res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  assign dac_code = trial_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS        = 12,
  parameter int SAMPLE_HALF  = 5,
  parameter int BASE_HALF    = 2,
  parameter int STRETCH_BIT  = 5,
  parameter int STRETCH_HALF = 4,
  parameter int LSB_HALF     = 3,
  localparam int BW = $clog2(NBITS)
) (
  input  logic             clk2x,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             cmp_hi,
  output logic             conv_clk,
  output logic             sample_en,
  output logic             busy_n,
  output logic [NBITS-1:0] dac_code,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [NBITS-1:0] res_code
);
  logic          rise_next;
  logic          begin_s, first_s, step_s, last_s;
  logic [BW-1:0] bit_s;

  sar_phase u_phase (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .conv_clk  (conv_clk),
    .rise_next (rise_next)
  );

  sar_ctrl #(
    .NBITS        (NBITS),
    .SAMPLE_HALF  (SAMPLE_HALF),
    .BASE_HALF    (BASE_HALF),
    .STRETCH_BIT  (STRETCH_BIT),
    .STRETCH_HALF (STRETCH_HALF),
    .LSB_HALF     (LSB_HALF)
  ) u_ctrl (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .start_n   (start_n),
    .rise_next (rise_next),
    .res_valid (res_valid),
    .begin_o   (begin_s),
    .first_o   (first_s),
    .step_o    (step_s),
    .last_o    (last_s),
    .bit_o     (bit_s),
    .busy_n    (busy_n),
    .sample_en (sample_en)
  );

  sar_trial #(.NBITS(NBITS)) u_trial (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .begin_i   (begin_s),
    .first_i   (first_s),
    .step_i    (step_s),
    .last_i    (last_s),
    .bit_i     (bit_s),
    .cmp_hi    (cmp_hi),
    .res_ready (res_ready),
    .dac_code  (dac_code),
    .res_code  (res_code),
    .res_valid (res_valid)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NBITS        = 12,
  parameter int SAMPLE_HALF  = 5,
  parameter int BASE_HALF    = 2,
  parameter int STRETCH_HALF = 4,
  parameter int LSB_HALF     = 3,
  localparam int TOTAL_HALF = SAMPLE_HALF + (NBITS - 2) * BASE_HALF
                              + STRETCH_HALF + LSB_HALF,
  localparam int LW = $clog2(TOTAL_HALF + 2) + 1
) (
  input logic             clk2x,
  input logic             rst_n,
  input logic             conv_clk,
  input logic             sample_en,
  input logic             busy_n,
  input logic [NBITS-1:0] dac_code,
  input logic             res_valid,
  input logic             res_ready,
  input logic [NBITS-1:0] res_code
);
  logic [LW-1:0] low_cnt;
  logic [LW-1:0] samp_cnt;

  always_ff @(posedge clk2x) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      samp_cnt <= '0;
    end else begin
      low_cnt  <= busy_n ? '0 : low_cnt + LW'(1);
      samp_cnt <= sample_en ? samp_cnt + LW'(1) : '0;
    end
  end

  // R1
  p_reset_idle_r1: assert property (@(posedge clk2x)
    !rst_n |=> (busy_n && !res_valid && !sample_en && dac_code == '0));

  p_conv_toggle_r2: assert property (@(posedge clk2x) disable iff (!rst_n)
    $past(rst_n) |-> (conv_clk != $past(conv_clk)));

  p_start_on_rise_r2: assert property (@(posedge clk2x) disable iff (!rst_n)
    $fell(busy_n) |-> conv_clk);

  p_sample_len_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
    $fell(sample_en) |-> (samp_cnt == LW'(SAMPLE_HALF)
                          && dac_code == {1'b1, {(NBITS-1){1'b0}}}));

  p_sample_dac_zero_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
    sample_en |-> (dac_code == '0));

  p_busy_len_r8: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(busy_n) |-> (low_cnt == LW'(TOTAL_HALF) && res_valid));

  p_hold_result_r9: assert property (@(posedge clk2x) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_code)));

  p_valid_idle_r11: assert property (@(posedge clk2x) disable iff (!rst_n)
    res_valid |-> busy_n);
endmodule

bind sar_seq sar_seq_chk #(
  .NBITS        (NBITS),
  .SAMPLE_HALF  (SAMPLE_HALF),
  .BASE_HALF    (BASE_HALF),
  .STRETCH_HALF (STRETCH_HALF),
  .LSB_HALF     (LSB_HALF)
) u_chk (.*);

// File: tb/sim_sar_seq.sv
`timescale 1ns/1ps
module sim_sar_seq;
  localparam int N = 12;

  logic         clk2x = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_n = 1'b1;
  logic         res_ready = 1'b1;
  logic [N-1:0] vin = '0;
  logic         cmp_hi;
  logic         conv_clk, sample_en, busy_n, res_valid;
  logic [N-1:0] dac_code, res_code;

  int n_checks = 0;
  int n_fails  = 0;
  int busy_cnt, samp_cnt, samp_dac_bad;
  int fs [N];
  bit finished = 1'b0;

  always #5 clk2x = ~clk2x;

  // comparator model: DAC above the input
  assign cmp_hi = (dac_code > vin);

  sar_seq u0 (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .start_n   (start_n),
    .cmp_hi    (cmp_hi),
    .conv_clk  (conv_clk),
    .sample_en (sample_en),
    .busy_n    (busy_n),
    .dac_code  (dac_code),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_code  (res_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse start_n at a negedge where conv_clk reads want; leaves us at the
  // first negedge where busy_n reads 0.
  task automatic kick(input logic want);
    int guard;
    guard = 0;
    @(negedge clk2x);
    while (conv_clk !== want && guard < 4) begin @(negedge clk2x); guard++; end
    start_n = 1'b0;
    @(negedge clk2x);
    start_n = 1'b1;
    if (want == 1'b1) begin
      chk(busy_n == 1'b1, "R2 wait for rise", int'(busy_n), 1);
      @(negedge clk2x);
    end
    chk(busy_n == 1'b0, "R2 busy fall", int'(busy_n), 0);
    chk(conv_clk == 1'b1, "R2 conv_clk high", int'(conv_clk), 1);
  endtask

  // Count negedges from the busy fall; optionally pulse start at offset pulse_at.
  task automatic measure(input int pulse_at);
    int n;
    n = 0; samp_cnt = 0; samp_dac_bad = 0;
    for (int k = 0; k < N; k++) fs[k] = -1;
    while (busy_n == 1'b0 && n < 40) begin
      if (sample_en) begin
        samp_cnt++;
        if (dac_code != '0) samp_dac_bad++;
      end
      for (int k = 0; k < N; k++) if (dac_code[k] && fs[k] < 0) fs[k] = n;
      start_n = (n == pulse_at) ? 1'b0 : 1'b1;
      @(negedge clk2x);
      n++;
    end
    start_n = 1'b1;
    busy_cnt = n;
  endtask

  task automatic t_reset();
    chk(busy_n == 1'b1, "R1 busy_n", int'(busy_n), 1);
    chk(conv_clk == 1'b0, "R1 conv_clk", int'(conv_clk), 0);
    chk(sample_en == 1'b0, "R1 sample_en", int'(sample_en), 0);
    chk(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
    chk(dac_code == '0, "R1 dac_code", int'(dac_code), 0);
  endtask

  task automatic t_timing();
    vin = '0;
    kick(1'b0);
    measure(-1);
    chk(samp_cnt == 5, "R3 sample length", samp_cnt, 5);
    chk(samp_dac_bad == 0, "R3 dac zero while sampling", samp_dac_bad, 0);
    chk(fs[11] == 5, "R5 bit11 offset", fs[11], 5);
    chk(fs[10] == 7, "R5 bit10 offset", fs[10], 7);
    chk(fs[6] == 15, "R5 bit6 offset", fs[6], 15);
    chk(fs[5] == 17, "R6 bit5 offset", fs[5], 17);
    chk(fs[4] == 21, "R6 bit4 offset", fs[4], 21);
    chk(fs[1] == 27, "R5 bit1 offset", fs[1], 27);
    chk(fs[0] == 29, "R7 bit0 offset", fs[0], 29);
    chk(busy_cnt == 32, "R8 busy length", busy_cnt, 32);
    chk(res_valid == 1'b1, "R8 valid at release", int'(res_valid), 1);
    chk(res_code == 12'd0, "R4 code", int'(res_code), 0);
  endtask

  task automatic t_code(input logic [N-1:0] v, input logic want);
    vin = v;
    kick(want);
    measure(-1);
    chk(busy_cnt == 32, "R8 busy length", busy_cnt, 32);
    chk(res_valid == 1'b1, "R8 valid", int'(res_valid), 1);
    chk(res_code == v, "R4 code", int'(res_code), int'(v));
    chk(fs[5] == 17, "R6 bit5 offset", fs[5], 17);
  endtask

  task automatic t_busy_start();
    vin = 12'h5A3;
    kick(1'b0);
    measure(10);
    chk(busy_cnt == 32, "R10 busy length with strobe", busy_cnt, 32);
    chk(res_code == 12'h5A3, "R10 code", int'(res_code), 12'h5A3);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk2x);
      chk(busy_n == 1'b1, "R10 no second conversion", int'(busy_n), 1);
    end
  endtask

  task automatic t_backpressure();
    vin = 12'h3C3;
    res_ready = 1'b0;
    kick(1'b0);
    measure(-1);
    chk(res_valid == 1'b1, "R9 valid", int'(res_valid), 1);
    for (int i = 0; i < 5; i++) begin
      start_n = (i == 1) ? 1'b0 : 1'b1;
      @(negedge clk2x);
      chk(res_valid == 1'b1, "R9 valid held", int'(res_valid), 1);
      chk(res_code == 12'h3C3, "R9 code held", int'(res_code), 12'h3C3);
      chk(busy_n == 1'b1, "R11 start ignored", int'(busy_n), 1);
    end
    start_n = 1'b1;
    res_ready = 1'b1;
    @(negedge clk2x);
    chk(res_valid == 1'b0, "R9 valid cleared", int'(res_valid), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk2x);
      chk(busy_n == 1'b1, "R11 no late start", int'(busy_n), 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk2x);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk2x);
    t_timing();
    t_code(12'hFFF, 1'b1);
    t_code(12'hA5C, 1'b0);
    t_code(12'h020, 1'b1);
    t_code(12'h001, 1'b0);
    t_code(12'h800, 1'b0);
    t_busy_start();
    t_backpressure();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule